// File: doc/BRIEF.md
# Shared FIFO Pool Partitioner with Pause Control

This block carves a fixed amount of queue storage into per-channel regions at run time. There are two peripheral classes, class A with `NUM_A` channels and class B with `NUM_B` channels. Each class has its own receive pool and its own transmit pool, each `POOL_DEPTH` entries deep, which gives four pools. Software stages a size for each channel queue. A size of zero turns that queue off. An update strobe then commits the staged sizes of one class, for the receive pool, the transmit pool or both. A committed partition places the queues back to back in channel order, starting at offset 0 of the pool. The pool's remaining unallocated space is reported.

Each pool has its own pause control. While a pool is paused, its queues accept no push and no pop. A commit is honoured only while the pool is paused and all its queues are empty, so a live queue is never relocated. A commit does not unpause the pool. Software must clear the pause explicitly before traffic resumes. The block keeps an occupancy count for every queue, which gives the empty status. The data storage itself belongs to the peripherals and is not part of this block.

Top module: `sfp_pool_mgr`

## Requirements
- R1: After reset, all four pools are paused. Every committed and staged size is 0, every base is 0, every count is 0, and every pool's free space equals `POOL_DEPTH`. Both status words have bits 1, 2, 9 and 10 set and all other bits clear.
- R2: `cfg_we` stages `cfg_size` for queue (`cfg_dir`, `cfg_chan`). Channels 0..NUM_A-1 belong to class A, and channels NUM_A..NUM_A+NUM_B-1 are class B channels 0.. in order. Direction 0 is receive and direction 1 is transmit. Staging alone leaves the committed sizes unchanged, and a `cfg_chan` of NUM_A+NUM_B or more is ignored.
- R3: A commit of pool p is requested when `upd_strobe` is high, `upd_class` matches (0 = A, 1 = B) and `upd_dirs[dir]` is set (bit 0 = receive, bit 1 = transmit). The commit is accepted when p is paused, every queue of p is empty and the staged total is at most `POOL_DEPTH`. From the next cycle, the sizes equal the staged values and each base equals the sum of the sizes of the lower channels of the same pool. Free space then equals `POOL_DEPTH` minus the total.
- R4: A commit request for a pool that is not paused changes none of that pool's sizes, bases or free space.
- R5: A commit request for a pool that has any queue with a nonzero count changes none of that pool's sizes, bases or free space.
- R6: A commit request whose staged total exceeds `POOL_DEPTH` is rejected and leaves that pool's committed state unchanged.
- R7: The pools are indexed p = 2*class + dir. `pause_set[p]` pauses pool p from the next cycle and `pause_clr[p]` unpauses it. When both are high, set wins. A commit never changes the pause state.
- R8: A push to queue q is accepted (`q_push_ok`) when its pool is unpaused and its count is below its size, so a size-0 queue never accepts a push. A pop is accepted when its pool is unpaused and its count is nonzero. The count changes by accepted pushes minus accepted pops from the next cycle. Queue index q = dir*(NUM_A+NUM_B) + channel.
- R9: While a pool is paused, no push or pop of its queues is accepted and their counts hold.
- R10: For each class, status bit 1 is the receive pool's pause state and bit 2 is 1 exactly when all of that class's receive queues have count 0. Bits 9 and 10 give the same for the transmit pool. All other status bits read 0. `stat_a` carries class A and `stat_b` carries class B.
- R11: A commit, a pause or a staging write acts only on its own pool. The committed state, pause state and counts of the other pools are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Stage a queue size |
| cfg_dir | input | 1 | Direction of staged queue (0 receive, 1 transmit) |
| cfg_chan | input | CW | Channel of staged queue |
| cfg_size | input | SW | Staged size in entries |
| upd_strobe | input | 1 | Commit request |
| upd_class | input | 1 | Class to commit (0 A, 1 B) |
| upd_dirs | input | 2 | Directions to commit (bit 0 receive, bit 1 transmit) |
| pause_set | input | 4 | Pause request per pool p = 2*class+dir |
| pause_clr | input | 4 | Unpause request per pool |
| q_push | input | NQ | Push request per queue |
| q_pop | input | NQ | Pop request per queue |
| q_push_ok | output | NQ | Push accepted this cycle |
| q_pop_ok | output | NQ | Pop accepted this cycle |
| q_size | output | NQ*SW | Committed size per queue |
| q_base | output | NQ*SW | Committed base offset in its pool per queue |
| q_count | output | NQ*SW | Occupancy per queue |
| free_space | output | 4*SW | Unallocated entries per pool |
| stat_a | output | 16 | Class A pause and empty status |
| stat_b | output | 16 | Class B pause and empty status |

## Verification
The bench builds the block with its defaults: four class A channels, two class B channels and a 16-entry pool. With a pool that small, a few modest staged sizes are enough to overflow the pool, to fill it exactly to zero free space, or to leave a size-0 queue in the middle of the base chain. A queue can be filled to its limit in a handful of pushes, which exercises the full-queue refusal and the combined push and pop. A behavioural model of every pool is compared with all outputs on every cycle, through directed sequences and then a random phase.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    // Status word layout; a neighbouring controller decodes these bits.
    localparam int STAT_W       = 16;
    localparam int SB_RX_HOLD   = 1;
    localparam int SB_RX_DRAIN  = 2;
    localparam int SB_TX_HOLD   = 9;
    localparam int SB_TX_DRAIN  = 10;

    localparam int NUM_POOLS    = 4;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    // Pool index: two pools per class, receive first.
    function automatic int pool_index(int cls, int dir);
        return cls * 2 + dir;
    endfunction

endpackage

// File: rtl/sfp_pause_ctl.sv
module sfp_pause_ctl #(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] set_i,
    input  logic [NP-1:0] clr_i,
    output logic [NP-1:0] paused_o
);

    typedef struct packed {
        logic [NP-1:0] paused;
    } pause_st_t;

    pause_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NP; i++) begin
            if (set_i[i]) begin
                st_d.paused[i] = 1'b1;
            end else if (clr_i[i]) begin
                st_d.paused[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.paused <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign paused_o = st_q.paused;

    for (genvar i = 0; i < NP; i++) begin : g_chk
        // R7: set wins and takes effect next cycle
        p_set_pauses_r7: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> paused_o[i]);
        p_clr_unpauses_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !paused_o[i]);
        p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(paused_o[i]));
    end

endmodule

// File: rtl/sfp_partition.sv
module sfp_partition #(
    parameter int NP    = 4,
    parameter int DEPTH = 16,
    parameter int SW    = 5,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [SW-1:0]    wr_size,
    input  logic             commit_req,
    input  logic             paused,
    input  logic             empty,
    output logic [NP*SW-1:0] size_o,
    output logic [NP*SW-1:0] base_o,
    output logic [SW-1:0]    free_o
);

    localparam int TW = SW + $clog2(NP + 1);

    typedef struct packed {
        logic [NP-1:0][SW-1:0] pend;
        logic [NP-1:0][SW-1:0] size;
        logic [NP-1:0][SW-1:0] base;
        logic [SW-1:0]         free;
    } part_st_t;

    part_st_t st_d, st_q;

    logic [NP-1:0][TW-1:0] prefix;
    logic [TW-1:0]         total;
    logic [TW-1:0]         remain;
    logic                  accept;

    always_comb begin
        st_d  = st_q;
        total = '0;
        for (int k = 0; k < NP; k++) begin
            prefix[k] = total;
            total     = total + {{(TW-SW){1'b0}}, st_q.pend[k]};
        end
        remain = TW'(DEPTH) - total;
        accept = commit_req && paused && empty && (total <= TW'(DEPTH));
        if (accept) begin
            st_d.size = st_q.pend;
            st_d.free = remain[SW-1:0];
            for (int k = 0; k < NP; k++) begin
                st_d.base[k] = prefix[k][SW-1:0];
            end
        end
        if (wr_en && ({1'b0, wr_idx} < (IW+1)'(NP))) begin
            st_d.pend[wr_idx] = wr_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.size <= '0;
            st_q.base <= '0;
            st_q.free <= SW'(DEPTH);
        end else begin
            st_q <= st_d;
        end
    end

    assign size_o = st_q.size;
    assign base_o = st_q.base;
    assign free_o = st_q.free;

    // Checker-side sum of committed sizes.
    logic [TW-1:0] size_sum;
    always_comb begin
        size_sum = '0;
        for (int k = 0; k < NP; k++) begin
            size_sum = size_sum + {{(TW-SW){1'b0}}, st_q.size[k]};
        end
    end

    // R4 and R5: sizes move only after a cycle that was paused and empty
    p_commit_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.size != $past(st_q.size)) |-> $past(paused && empty));

    // R6: committed sizes plus free space always cover the pool exactly
    p_pool_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sum + {{(TW-SW){1'b0}}, st_q.free}) == TW'(DEPTH));

    for (genvar k = 1; k < NP; k++) begin : g_chain
        // R3: queues sit back to back in channel order
        p_base_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.base[k] == st_q.base[k-1] + st_q.size[k-1]);
    end

    p_base_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.base[0] == '0);

endmodule

// File: rtl/sfp_occupancy.sv
module sfp_occupancy #(
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          paused,
    input  logic [SW-1:0] size,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [SW-1:0] count
);

    typedef struct packed {
        logic [SW-1:0] count;
    } occ_st_t;

    occ_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        push_ok = push && !paused && (st_q.count < size);
        pop_ok  = pop && !paused && (st_q.count != '0);
        if (push_ok && !pop_ok) begin
            st_d.count = st_q.count + SW'(1);
        end else if (pop_ok && !push_ok) begin
            st_d.count = st_q.count - SW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.count <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;

    // R9: a paused queue keeps its occupancy
    p_hold_paused_r9: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> $stable(count));

    // R8: occupancy never exceeds the committed size
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= size);

endmodule

// File: rtl/sfp_pool_mgr.sv
module sfp_pool_mgr
    import sfp_pkg::*;
#(
    parameter int  NUM_A      = 4,
    parameter int  NUM_B      = 2,
    parameter int  POOL_DEPTH = 16,
    localparam int NCH        = NUM_A + NUM_B,
    localparam int NQ         = 2 * NCH,
    localparam int SW         = $clog2(POOL_DEPTH + 1),
    localparam int CW         = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_dir,
    input  logic [CW-1:0]     cfg_chan,
    input  logic [SW-1:0]     cfg_size,
    input  logic              upd_strobe,
    input  logic              upd_class,
    input  logic [1:0]        upd_dirs,
    input  logic [3:0]        pause_set,
    input  logic [3:0]        pause_clr,
    input  logic [NQ-1:0]     q_push,
    input  logic [NQ-1:0]     q_pop,
    output logic [NQ-1:0]     q_push_ok,
    output logic [NQ-1:0]     q_pop_ok,
    output logic [NQ*SW-1:0]  q_size,
    output logic [NQ*SW-1:0]  q_base,
    output logic [NQ*SW-1:0]  q_count,
    output logic [4*SW-1:0]   free_space,
    output logic [STAT_W-1:0] stat_a,
    output logic [STAT_W-1:0] stat_b
);

    logic [NUM_POOLS-1:0] paused;
    logic [NUM_POOLS-1:0] pool_empty;
    logic [NQ-1:0]        q_busy;

    logic          chan_ok;
    logic          chan_is_b;
    logic [CW-1:0] chan_local;

    assign chan_ok    = {1'b0, cfg_chan} < (CW+1)'(NCH);
    assign chan_is_b  = {1'b0, cfg_chan} >= (CW+1)'(NUM_A);
    assign chan_local = chan_is_b ? (cfg_chan - CW'(NUM_A)) : cfg_chan;

    sfp_pause_ctl #(.NP(NUM_POOLS)) u_pause (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (pause_set),
        .clr_i    (pause_clr),
        .paused_o (paused)
    );

    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
        localparam int CLS  = p / 2;
        localparam int DIR  = p % 2;
        localparam int NP   = (CLS == 0) ? NUM_A : NUM_B;
        localparam int QOFF = DIR * NCH + ((CLS == 0) ? 0 : NUM_A);

        logic wr_hit;
        logic commit;

        assign wr_hit = cfg_we && chan_ok && (cfg_dir == 1'(DIR)) && (chan_is_b == 1'(CLS));
        assign commit = upd_strobe && (upd_class == 1'(CLS)) && upd_dirs[DIR];
        assign pool_empty[p] = ~|q_busy[QOFF +: NP];

        sfp_partition #(
            .NP    (NP),
            .DEPTH (POOL_DEPTH),
            .SW    (SW),
            .IW    (CW)
        ) u_part (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_hit),
            .wr_idx     (chan_local),
            .wr_size    (cfg_size),
            .commit_req (commit),
            .paused     (paused[p]),
            .empty      (pool_empty[p]),
            .size_o     (q_size[QOFF*SW +: NP*SW]),
            .base_o     (q_base[QOFF*SW +: NP*SW]),
            .free_o     (free_space[p*SW +: SW])
        );

        // R7: a commit leaves the pause state alone
        p_commit_keeps_pause_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && !pause_set[p] && !pause_clr[p]) |=> $stable(paused[p]));
    end

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        localparam int DQ = q / NCH;
        localparam int CH = q % NCH;
        localparam int PQ = ((CH >= NUM_A) ? 2 : 0) + DQ;

        sfp_occupancy #(.SW(SW)) u_occ (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (q_push[q]),
            .pop     (q_pop[q]),
            .paused  (paused[PQ]),
            .size    (q_size[q*SW +: SW]),
            .push_ok (q_push_ok[q]),
            .pop_ok  (q_pop_ok[q]),
            .count   (q_count[q*SW +: SW])
        );

        assign q_busy[q] = |q_count[q*SW +: SW];
    end

    always_comb begin
        stat_a = '0;
        stat_b = '0;
        stat_a[SB_RX_HOLD]  = paused[pool_index(0, 0)];
        stat_a[SB_RX_DRAIN] = pool_empty[pool_index(0, 0)];
        stat_a[SB_TX_HOLD]  = paused[pool_index(0, 1)];
        stat_a[SB_TX_DRAIN] = pool_empty[pool_index(0, 1)];
        stat_b[SB_RX_HOLD]  = paused[pool_index(1, 0)];
        stat_b[SB_RX_DRAIN] = pool_empty[pool_index(1, 0)];
        stat_b[SB_TX_HOLD]  = paused[pool_index(1, 1)];
        stat_b[SB_TX_DRAIN] = pool_empty[pool_index(1, 1)];
    end

endmodule

// File: tb/sfp_pool_mgr_test.sv
module sfp_pool_mgr_test;

    localparam int CLK_PERIOD = 10;
    localparam int NA    = 4;
    localparam int NB    = 2;
    localparam int DEPTH = 16;
    localparam int NCH   = NA + NB;
    localparam int NQ    = 2 * NCH;
    localparam int SW    = $clog2(DEPTH + 1);
    localparam int CW    = $clog2(NCH);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_we;
    logic              cfg_dir;
    logic [CW-1:0]     cfg_chan;
    logic [SW-1:0]     cfg_size;
    logic              upd_strobe;
    logic              upd_class;
    logic [1:0]        upd_dirs;
    logic [3:0]        pause_set;
    logic [3:0]        pause_clr;
    logic [NQ-1:0]     q_push;
    logic [NQ-1:0]     q_pop;
    logic [NQ-1:0]     q_push_ok;
    logic [NQ-1:0]     q_pop_ok;
    logic [NQ*SW-1:0]  q_size;
    logic [NQ*SW-1:0]  q_base;
    logic [NQ*SW-1:0]  q_count;
    logic [4*SW-1:0]   free_space;
    logic [15:0]       stat_a;
    logic [15:0]       stat_b;

    sfp_pool_mgr #(.NUM_A(NA), .NUM_B(NB), .POOL_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dir(cfg_dir),
        .cfg_chan(cfg_chan), .cfg_size(cfg_size), .upd_strobe(upd_strobe),
        .upd_class(upd_class), .upd_dirs(upd_dirs), .pause_set(pause_set),
        .pause_clr(pause_clr), .q_push(q_push), .q_pop(q_pop),
        .q_push_ok(q_push_ok), .q_pop_ok(q_pop_ok), .q_size(q_size),
        .q_base(q_base), .q_count(q_count), .free_space(free_space),
        .stat_a(stat_a), .stat_b(stat_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  checks = 0;
    int  errs   = 0;
    bit  done   = 0;

    // Behavioural model state
    int  m_pend [NQ];
    int  m_size [NQ];
    int  m_base [NQ];
    int  m_cnt  [NQ];
    bit  m_pause[4];
    int  m_free [4];

    function automatic int pool_of(int q);
        return (((q % NCH) >= NA) ? 2 : 0) + q / NCH;
    endfunction

    function automatic bit pool_empty(int p);
        for (int q = 0; q < NQ; q++) begin
            if (pool_of(q) == p && m_cnt[q] != 0) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit exp_push(int q);
        return q_push[q] && !m_pause[pool_of(q)] && (m_cnt[q] < m_size[q]);
    endfunction

    function automatic bit exp_pop(int q);
        return q_pop[q] && !m_pause[pool_of(q)] && (m_cnt[q] > 0);
    endfunction

    function automatic int exp_stat(int cls);
        int s = 0;
        if (m_pause[cls*2])      s |= (1 << 1);
        if (pool_empty(cls*2))   s |= (1 << 2);
        if (m_pause[cls*2+1])    s |= (1 << 9);
        if (pool_empty(cls*2+1)) s |= (1 << 10);
        return s;
    endfunction

    task automatic model_reset();
        for (int q = 0; q < NQ; q++) begin
            m_pend[q] = 0; m_size[q] = 0; m_base[q] = 0; m_cnt[q] = 0;
        end
        for (int p = 0; p < 4; p++) begin
            m_pause[p] = 1'b1; m_free[p] = DEPTH;
        end
    endtask

    task automatic model_advance();
        bit pok[NQ];
        bit ook[NQ];
        bit emp[4];
        for (int q = 0; q < NQ; q++) begin
            pok[q] = exp_push(q);
            ook[q] = exp_pop(q);
        end
        for (int p = 0; p < 4; p++) emp[p] = pool_empty(p);
        // commits use state from before this edge
        if (upd_strobe) begin
            for (int d = 0; d < 2; d++) begin
                int p = int'(upd_class) * 2 + d;
                int sum = 0;
                if (!upd_dirs[d]) continue;
                for (int q = 0; q < NQ; q++) if (pool_of(q) == p) sum += m_pend[q];
                if (m_pause[p] && emp[p] && sum <= DEPTH) begin
                    int run = 0;
                    for (int q = 0; q < NQ; q++) begin
                        if (pool_of(q) == p) begin
                            m_size[q] = m_pend[q];
                            m_base[q] = run;
                            run += m_pend[q];
                        end
                    end
                    m_free[p] = DEPTH - sum;
                end
            end
        end
        for (int q = 0; q < NQ; q++) m_cnt[q] += int'(pok[q]) - int'(ook[q]);
        for (int p = 0; p < 4; p++) begin
            if (pause_set[p]) m_pause[p] = 1'b1;
            else if (pause_clr[p]) m_pause[p] = 1'b0;
        end
        if (cfg_we && int'(cfg_chan) < NCH) m_pend[int'(cfg_dir) * NCH + int'(cfg_chan)] = int'(cfg_size);
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        for (int q = 0; q < NQ; q++) begin
            chk(tag, $sformatf("size q%0d", q),  int'(q_size[q*SW +: SW]),  m_size[q]);
            chk(tag, $sformatf("base q%0d", q),  int'(q_base[q*SW +: SW]),  m_base[q]);
            chk(tag, $sformatf("count q%0d", q), int'(q_count[q*SW +: SW]), m_cnt[q]);
            chk(tag, $sformatf("push_ok q%0d", q), int'(q_push_ok[q]), int'(exp_push(q)));
            chk(tag, $sformatf("pop_ok q%0d", q),  int'(q_pop_ok[q]),  int'(exp_pop(q)));
        end
        for (int p = 0; p < 4; p++) begin
            chk(tag, $sformatf("free p%0d", p), int'(free_space[p*SW +: SW]), m_free[p]);
        end
        chk(tag, "stat_a", int'(stat_a), exp_stat(0));
        chk(tag, "stat_b", int'(stat_b), exp_stat(1));
    endtask

    task automatic clear_inputs();
        cfg_we = 0; cfg_dir = 0; cfg_chan = '0; cfg_size = '0;
        upd_strobe = 0; upd_class = 0; upd_dirs = '0;
        pause_set = '0; pause_clr = '0; q_push = '0; q_pop = '0;
    endtask

    task automatic cycle(string tag);
        #1;
        compare(tag);
        @(posedge clk);
        model_advance();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic stage(string tag, int dir, int chan, int size);
        cfg_we = 1; cfg_dir = 1'(dir); cfg_chan = CW'(chan); cfg_size = SW'(size);
        cycle(tag);
    endtask

    task automatic commit(string tag, int cls, int dirs);
        upd_strobe = 1; upd_class = 1'(cls); upd_dirs = 2'(dirs);
        cycle(tag);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        clear_inputs();
        model_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        cycle("R1");
        cycle("R1");

        // R2: staging alone changes nothing committed; out-of-range channel ignored
        stage("R2", 0, 0, 4);
        stage("R2", 0, 1, 0);
        stage("R2", 0, 2, 5);
        stage("R2", 0, 3, 3);
        stage("R2", 0, 7, 9);
        stage("R2", 0, 6, 9);
        cycle("R2");

        // R3: commit class A receive pool (paused, empty, total 12)
        commit("R3", 0, 1);
        cycle("R3");

        // R7: unpause class A receive pool
        pause_clr[0] = 1; cycle("R7");

        // R8: fill queue 0 to its size, then refuse; size-0 queue refuses
        for (int i = 0; i < 5; i++) begin
            q_push[0] = 1; q_push[1] = 1; cycle("R8");
        end
        q_push[0] = 1; q_pop[0] = 1; cycle("R8");
        q_push[2] = 1; cycle("R8");
        q_push[2] = 1; q_pop[2] = 1; cycle("R8");

        // R4: commit while unpaused is ignored
        stage("R4", 0, 3, 1);
        commit("R4", 0, 1);
        cycle("R4");

        // R9: paused pool blocks traffic and holds counts
        pause_set[0] = 1; cycle("R9");
        q_push[0] = 1; q_pop[2] = 1; cycle("R9");
        q_pop[0] = 1; cycle("R9");

        // R5: paused but not empty, commit ignored
        commit("R5", 0, 1);
        cycle("R5");

        // R7: set and clear together, set wins
        pause_set[0] = 1; pause_clr[0] = 1; cycle("R7");
        cycle("R7");

        // R10: drain and watch the empty bit
        pause_clr[0] = 1; cycle("R10");
        for (int i = 0; i < 6; i++) begin
            q_pop[0] = 1; q_pop[2] = 1; cycle("R10");
        end
        pause_set[0] = 1; cycle("R10");

        // R6: oversize total rejected
        stage("R6", 0, 3, 9);
        commit("R6", 0, 1);
        cycle("R6");

        // R3: exact fit, free space zero
        stage("R3", 0, 3, 7);
        commit("R3", 0, 1);
        cycle("R3");

        // R11: class B commits both directions; class A pools untouched
        stage("R11", 1, 4, 6);
        stage("R11", 1, 5, 10);
        stage("R11", 0, 4, 2);
        commit("R11", 1, 3);
        cycle("R11");
        pause_clr[3] = 1; cycle("R11");
        q_push[NCH+5] = 1; q_push[0] = 1; cycle("R10");
        cycle("R10");
        pause_clr[2] = 1; cycle("R11");
        q_push[4] = 1; cycle("R11");
        commit("R11", 0, 2);
        cycle("R11");

        // Random phase
        for (int i = 0; i < 2000; i++) begin
            q_push = NQ'($urandom);
            q_pop  = NQ'($urandom);
            if ($urandom_range(0, 7) == 0) pause_set = 4'($urandom);
            if ($urandom_range(0, 3) == 0) pause_clr = 4'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                cfg_we = 1; cfg_dir = 1'($urandom); cfg_chan = CW'($urandom);
                cfg_size = SW'($urandom_range(0, 7));
            end
            if ($urandom_range(0, 7) == 0) begin
                upd_strobe = 1; upd_class = 1'($urandom); upd_dirs = 2'($urandom);
            end
            cycle("R8");
        end

        summary();
        $finish;
    end

endmodule